// File: doc/BRIEF.md
# Packed Rounding Halving Adder Unit

This block is a packed-SIMD execution unit that receives one 32-bit instruction word together with two 128-bit source vectors. It decodes the element type and the three 5-bit register numbers from fixed positions in the word. It treats the sources as packed lanes of 8, 16 or 32 bits, either signed or unsigned. In each lane it forms the sum of the two elements plus one, then keeps that sum shifted right by one bit. Each lane is computed one bit wider than the element, so the sum never overflows, and no carry passes from one lane into the next.

The vector length is 64 or 128 bits. In 64-bit mode only the low half of each source is used, and the high half of the result is zero. Words that do not match the fixed layout, or that use a reserved lane size, set an undefined flag. So do 128-bit words that name an odd register number. Such words produce a zero result and a zero destination.

The lane datapath is combinational. Its result is captured in an output register stage, which is controlled by a two-state machine. In state ST_IDLE the unit has no fresh result. In state ST_VALID a result captured on the previous edge is being presented. An input strobe moves the machine from either state to ST_VALID (transitions IDLE_TO_VALID and VALID_TO_VALID). A cycle without a strobe moves it to ST_IDLE (transitions VALID_TO_IDLE and IDLE_TO_IDLE). The captured values stay on the outputs until the next strobe.

Top module: `rhadd_simd_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe yet, `out_valid`, `undef_flag`, `dest_reg` and `result` are all zero.
- R2: `out_valid` is high in exactly the cycle that follows a cycle in which `in_valid` was high. Back-to-back strobes keep it high, and it is low in every other cycle.
- R3: For unsigned lanes, each result lane equals (a + b + 1) >> 1, computed without overflow. For example, 0xFF and 0xFF give 0xFF, and 0xFF and 0x01 give 0x80. No carry crosses into a neighbouring lane.
- R4: For signed lanes, each result lane equals floor((a + b + 1) / 2) on two's-complement values. For example, 8-bit 0x80 and 0x80 give 0x80, 0x7F and 0x7F give 0x7F, and 0xFF and 0xFE give 0xFF.
- R5: Instruction bits 21:20 select the lane width: 00 gives 8 bits, 01 gives 16 bits and 10 gives 32 bits.
- R6: Instruction bit 28 set to 1 selects unsigned lanes, and set to 0 selects signed lanes.
- R7: Instruction bit 6 set to 1 processes all 128 bits. Set to 0, it processes bits 63:0 only, and result bits 127:64 are zero whatever the sources hold.
- R8: For a legal word, `dest_reg` equals {bit 22, bits 15:12}. The source numbers are {bit 7, bits 19:16} and {bit 5, bits 3:0}.
- R9: A lane-size code of 11 sets `undef_flag`, and forces `result` and `dest_reg` to zero.
- R10: The fixed fields must read bits 31:29 = 111, bits 27:24 = 1111, bit 23 = 0, bits 11:8 = 0001 and bit 4 = 0. Any mismatch sets `undef_flag` with a zero result and a zero destination.
- R11: With bit 6 = 1, an odd destination or source register number sets `undef_flag` and zeroes the outputs. An odd number means bit 12, bit 16 or bit 0 is set. With bit 6 = 0, odd numbers are legal.
- R12: In a cycle without `in_valid`, `result`, `dest_reg` and `undef_flag` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: instruction and sources are presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | A result captured on the previous edge is presented |
| result | output | 128 | Packed result vector |
| dest_reg | output | 5 | Destination register number |
| undef_flag | output | 1 | The captured word was undefined |

## Verification
Two functions meet in the same cycle: the lane datapath and the undefined-word decode. An illegal word is evaluated in the same cycle as a full lane sum that would be non-zero. The bench provokes this by sending words whose sources hold large operands while one of the following is wrong: the size code, a fixed bit, or the parity of a register number in 128-bit mode. It judges that the result and destination are zero and the flag is set. It also sends odd register numbers in 64-bit mode and judges that the datapath result survives. This shows that the suppression is tied to the vector length and not to parity alone.

// File: rtl/rhadd_pkg.sv
package rhadd_pkg;

    typedef enum logic [1:0] {
        LW_8   = 2'b00,
        LW_16  = 2'b01,
        LW_32  = 2'b10,
        LW_BAD = 2'b11
    } lane_w_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } stage_e;

    typedef struct packed {
        logic       legal;
        lane_w_e    width;
        logic       is_unsigned;
        logic       wide;
        logic [4:0] rd;
        logic [4:0] rn;
        logic [4:0] rm;
    } dec_t;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;

endpackage

// File: rtl/rhadd_decode.sv
module rhadd_decode
    import rhadd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic fixed_ok;
    logic odd_in_wide;

    always_comb begin
        fixed_ok = (instr[31:29] == 3'b111) && (instr[27:24] == 4'b1111) &&
                   (instr[23] == 1'b0) && (instr[11:8] == 4'b0001) &&
                   (instr[4] == 1'b0);
        dec.width       = lane_w_e'(instr[21:20]);
        dec.is_unsigned = instr[28];
        dec.wide        = instr[6];
        dec.rd          = {instr[22], instr[15:12]};
        dec.rn          = {instr[7],  instr[19:16]};
        dec.rm          = {instr[5],  instr[3:0]};
        odd_in_wide     = dec.wide && (dec.rd[0] || dec.rn[0] || dec.rm[0]);
        dec.legal       = fixed_ok && (dec.width != LW_BAD) && !odd_in_wide;
    end
endmodule

// File: rtl/rhadd_lane.sv
module rhadd_lane #(
    parameter int W = 8
) (
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] sum;

    always_comb begin
        ext_a = {sgn & a[W-1], a};
        ext_b = {sgn & b[W-1], b};
        sum   = ext_a + ext_b + {{W{1'b0}}, 1'b1};
        y     = sum[W:1];
    end
endmodule

// File: rtl/rhadd_lane_array.sv
module rhadd_lane_array
    import rhadd_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int SLICE_W = 32
) (
    input  lane_w_e          width,
    input  logic             sgn,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] y
);
    localparam int NSLICE = VEC_W / SLICE_W;
    localparam int NBYTE  = SLICE_W / 8;
    localparam int NHALF  = SLICE_W / 16;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        logic [SLICE_W-1:0] sa, sb;
        logic [SLICE_W-1:0] y8, y16, y32;
        assign sa = a[s*SLICE_W +: SLICE_W];
        assign sb = b[s*SLICE_W +: SLICE_W];

        for (genvar k = 0; k < NBYTE; k++) begin : g_b
            rhadd_lane #(.W(8)) u_l8 (
                .sgn(sgn), .a(sa[k*8 +: 8]), .b(sb[k*8 +: 8]), .y(y8[k*8 +: 8]));
        end
        for (genvar h = 0; h < NHALF; h++) begin : g_h
            rhadd_lane #(.W(16)) u_l16 (
                .sgn(sgn), .a(sa[h*16 +: 16]), .b(sb[h*16 +: 16]), .y(y16[h*16 +: 16]));
        end
        rhadd_lane #(.W(SLICE_W)) u_l32 (.sgn(sgn), .a(sa), .b(sb), .y(y32));

        always_comb begin
            unique case (width)
                LW_8:    y[s*SLICE_W +: SLICE_W] = y8;
                LW_16:   y[s*SLICE_W +: SLICE_W] = y16;
                LW_32:   y[s*SLICE_W +: SLICE_W] = y32;
                default: y[s*SLICE_W +: SLICE_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/rhadd_out_stage.sv
module rhadd_out_stage
    import rhadd_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  dec_t             dec,
    input  logic [VEC_W-1:0] lanes,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic [REG_W-1:0] dest_reg,
    output logic             undef_flag
);
    localparam int HALF_W = VEC_W / 2;

    stage_e state, state_nxt;

    always_comb begin
        unique case (state)
            ST_IDLE:  state_nxt = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_nxt = in_valid ? ST_VALID : ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            dest_reg   <= '0;
            undef_flag <= 1'b0;
        end else if (in_valid) begin
            if (!dec.legal) begin
                result     <= '0;
                dest_reg   <= '0;
                undef_flag <= 1'b1;
            end else begin
                result     <= dec.wide ? lanes : {{HALF_W{1'b0}}, lanes[HALF_W-1:0]};
                dest_reg   <= dec.rd;
                undef_flag <= 1'b0;
            end
        end
    end

    assign out_valid = (state == ST_VALID);
endmodule

// File: rtl/rhadd_simd_unit.sv
module rhadd_simd_unit
    import rhadd_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result,
    output logic [REG_W-1:0]   dest_reg,
    output logic               undef_flag
);
    dec_t             dec;
    logic [VEC_W-1:0] lanes;

    rhadd_decode u_dec (.instr(instr), .dec(dec));

    rhadd_lane_array #(.VEC_W(VEC_W)) u_lanes (
        .width(dec.width), .sgn(!dec.is_unsigned),
        .a(src_a), .b(src_b), .y(lanes));

    rhadd_out_stage #(.VEC_W(VEC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec(dec), .lanes(lanes),
        .out_valid(out_valid), .result(result), .dest_reg(dest_reg),
        .undef_flag(undef_flag));
endmodule

// File: rtl/rhadd_checker.sv
module rhadd_checker #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      instr,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic [4:0]       dest_reg,
    input logic             undef_flag
);
    localparam int HALF_W = VEC_W / 2;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_UNDEF_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> (result == '0) && (dest_reg == '0)); // R9
    AST_SIZE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[21:20] == 2'b11) |=> undef_flag); // R9
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[6]) |=> (result[VEC_W-1:HALF_W] == '0)); // R7
    AST_ODD_WIDE_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[6] && (instr[12] || instr[16] || instr[0])) |=> undef_flag); // R11
    AST_FIXED_BIT4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[4]) |=> undef_flag); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(dest_reg) && $stable(undef_flag)); // R12
endmodule

bind rhadd_simd_unit rhadd_checker #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .out_valid(out_valid), .result(result), .dest_reg(dest_reg),
    .undef_flag(undef_flag));

// File: tb/tb_rhadd_simd_unit.sv
module tb_rhadd_simd_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic [127:0] result;
    logic [4:0]   dest_reg;
    logic         undef_flag;

    int checks = 0;
    int errors = 0;

    logic         exp_valid = 1'b0;
    logic [127:0] exp_res = '0;
    logic [4:0]   exp_dest = '0;
    logic         exp_undef = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rhadd_simd_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
        .dest_reg(dest_reg), .undef_flag(undef_flag));

    function automatic logic [31:0] mk(bit u, bit [1:0] sz, bit q,
                                       bit [4:0] d, bit [4:0] n, bit [4:0] m);
        return {3'b111, u, 4'b1111, 1'b0, d[4], sz, n[3:0], d[3:0],
                4'b0001, n[4], q, m[4], 1'b0, m[3:0]};
    endfunction

    task automatic ref_calc(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b,
                            output logic [127:0] r, output logic [4:0] dst, output logic un);
        bit bad;
        int w, nel;
        bad = (ins[31:29] != 3'b111) || (ins[27:24] != 4'hF) || ins[23] ||
              (ins[11:8] != 4'b0001) || ins[4] || (ins[21:20] == 2'b11) ||
              (ins[6] && (ins[12] || ins[16] || ins[0]));
        r = '0; dst = '0; un = 1'b1;
        if (!bad) begin
            un  = 1'b0;
            dst = {ins[22], ins[15:12]};
            w   = 8 << ins[21:20];
            nel = (ins[6] ? 128 : 64) / w;
            for (int i = 0; i < nel; i++) begin
                longint mask, ea, eb, s;
                logic [127:0] ta, tb;
                mask = (64'sd1 <<< w) - 1;
                ta = a >> (i*w);
                tb = b >> (i*w);
                ea = longint'(ta[63:0]) & mask;
                eb = longint'(tb[63:0]) & mask;
                if (!ins[28]) begin
                    if ((ea & (64'sd1 <<< (w-1))) != 0) ea = ea - (64'sd1 <<< w);
                    if ((eb & (64'sd1 <<< (w-1))) != 0) eb = eb - (64'sd1 <<< w);
                end
                s = (ea + eb + 1) >>> 1;
                r = r | ({64'd0, 64'(s & mask)} << (i*w));
            end
        end
    endtask

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drives at a falling edge, models the rising edge, compares at the next falling edge
    task automatic step(bit v, logic [31:0] ins, logic [127:0] a, logic [127:0] b, string tag);
        in_valid = v; instr = ins; src_a = a; src_b = b;
        @(posedge clk);
        exp_valid = v;
        if (v) ref_calc(ins, a, b, exp_res, exp_dest, exp_undef);
        @(negedge clk);
        chk({tag, " R2 valid"}, {127'd0, out_valid}, {127'd0, exp_valid});
        chk({tag, " result"}, result, exp_res);
        chk({tag, " R8 dest"}, {123'd0, dest_reg}, {123'd0, exp_dest});
        chk({tag, " undef"}, {127'd0, undef_flag}, {127'd0, exp_undef});
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] ones, pat;
        ones = '1;
        @(negedge clk);
        chk("R1 valid in reset", {127'd0, out_valid}, 128'd0);
        chk("R1 result in reset", result, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {127'd0, out_valid}, 128'd0);
        chk("R1 dest after reset", {123'd0, dest_reg}, 128'd0);
        chk("R1 undef after reset", {127'd0, undef_flag}, 128'd0);

        // R3 unsigned extremes and lane isolation
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd4, 5'd6), ones, ones, "R3 u8 max");
        chk("R3 u8 FF+FF", result, ones);
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd4, 5'd6), ones, {16{8'h01}}, "R3 u8 carry");
        chk("R3 u8 FF+01", result, {16{8'h80}});
        step(1, mk(1, 2'b01, 1, 5'd0, 5'd0, 5'd0), ones, {8{16'h0001}}, "R3 u16 carry");
        step(1, mk(1, 2'b10, 1, 5'd0, 5'd0, 5'd0), ones, ones, "R3 u32 max");
        // R4 signed extremes
        step(1, mk(0, 2'b00, 1, 5'd8, 5'd8, 5'd8), {16{8'h80}}, {16{8'h80}}, "R4 s8 min");
        chk("R4 s8 80+80", result, {16{8'h80}});
        step(1, mk(0, 2'b00, 1, 5'd8, 5'd8, 5'd8), {16{8'h7F}}, {16{8'h7F}}, "R4 s8 max");
        step(1, mk(0, 2'b00, 1, 5'd8, 5'd8, 5'd8), {16{8'hFF}}, {16{8'hFE}}, "R4 s8 neg");
        chk("R4 s8 FF+FE", result, {16{8'hFF}});
        step(1, mk(0, 2'b01, 1, 5'd8, 5'd8, 5'd8), {8{16'h8000}}, {8{16'h7FFF}}, "R4 s16 mix");
        step(1, mk(0, 2'b10, 1, 5'd8, 5'd8, 5'd8), {4{32'h80000000}}, {4{32'h80000000}}, "R4 s32 min");
        // R5 R6 random widths and signedness
        for (int i = 0; i < 48; i++) begin
            bit [1:0] sz;
            sz = 2'(i % 3);
            step(1, mk(1'(i / 3), sz, 1'(i / 6), 5'(2 * (i % 16)), 5'(2 * (i % 7)), 5'(2 * (i % 5))),
                 rnd128(), rnd128(), "R5 R6 random");
        end
        // R7 narrow mode clears the upper half
        step(1, mk(1, 2'b00, 0, 5'd3, 5'd5, 5'd7), ones, ones, "R7 narrow u8");
        chk("R7 upper half", {64'd0, result[127:64]}, 128'd0);
        step(1, mk(0, 2'b10, 0, 5'd17, 5'd1, 5'd31), rnd128(), rnd128(), "R7 R11 narrow odd legal");
        // R8 destination number
        step(1, mk(1, 2'b01, 0, 5'b10111, 5'd0, 5'd0), rnd128(), rnd128(), "R8 dest");
        chk("R8 dest value", {123'd0, dest_reg}, 128'd23);
        // R9 reserved size
        step(1, mk(1, 2'b11, 1, 5'd2, 5'd2, 5'd2), ones, ones, "R9 size11");
        // R10 fixed-bit mismatches
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd2, 5'd2) | 32'h0000_0010, ones, ones, "R10 bit4");
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd2, 5'd2) | 32'h0080_0000, ones, ones, "R10 bit23");
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd2, 5'd2) ^ 32'h0000_0300, ones, ones, "R10 bits11_8");
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd2, 5'd2) & 32'hDFFF_FFFF, ones, ones, "R10 bit29");
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd2, 5'd2) & 32'hFBFF_FFFF, ones, ones, "R10 bit26");
        // R11 odd registers in wide mode
        step(1, mk(1, 2'b00, 1, 5'd3, 5'd2, 5'd2), ones, ones, "R11 odd dest");
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd9, 5'd2), ones, ones, "R11 odd n");
        step(1, mk(1, 2'b00, 1, 5'd2, 5'd2, 5'd11), ones, ones, "R11 odd m");
        // R12 hold while idle, then back-to-back R2
        pat = rnd128();
        step(1, mk(1, 2'b01, 1, 5'd10, 5'd12, 5'd14), pat, pat, "R12 load");
        step(0, mk(0, 2'b11, 1, 5'd1, 5'd1, 5'd1), ones, '0, "R12 idle1");
        step(0, mk(1, 2'b00, 0, 5'd5, 5'd0, 5'd0), rnd128(), rnd128(), "R12 idle2");
        step(1, mk(0, 2'b00, 1, 5'd4, 5'd4, 5'd4), rnd128(), rnd128(), "R2 b2b 1");
        step(1, mk(1, 2'b10, 0, 5'd5, 5'd4, 5'd4), rnd128(), rnd128(), "R2 b2b 2");
        step(0, '0, '0, '0, "R2 drop");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule